// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block maintains even parity for a multiplexed address/data bus with a 32-bit data path and a 4-bit command/byte-enable path. The parity bit belongs to the bus word of the previous clock, so the parity pin always lags the data pins by exactly one cycle. The agent that drove a word also drives its parity. The block watches the framing and handshake strobes to find the cycles that carry valid words. A role input says whether this agent is the initiator or the target, and a direction input says whether the current transfer is a write or a read. From these the block decides which agent owns each valid word.

In the cycle after a word this agent owns, the block drives the computed parity bit and enables the parity driver. After a word owned by the other agent, it compares the sampled parity pin against the parity it computed from the captured word. On a mismatch it raises a one-cycle error flag one clock later. Cycles without a valid word never enable the driver and never raise an error. These include idle bus cycles and wait states.

Top module: `bus_parity_unit`

## Requirements
- R1: While reset is asserted (active-low `rstN`), `parOe` and `parErr` are 0, and `parOut` is 0.
- R2: In every cycle after reset, `parOut` equals the value that makes the count of ones across the previous cycle's `adIn`, `cbeIn` and `parOut` even.
- R3: An address cycle is a cycle with `frameN` low that follows a cycle where `frameN` and `irdyN` were both high. It is always a valid word owned by the initiator (`isMaster`=1 means this agent is the initiator).
- R4: In a write (`isWrite`=1), each cycle after the address cycle with `irdyN` low holds a valid word owned by the initiator.
- R5: In a read (`isWrite`=0), each cycle after the address cycle with `trdyN` low holds a valid word owned by the target.
- R6: `parOe` is high in exactly the cycles that follow a valid word owned by this agent. It is never high after an idle cycle or a wait state.
- R7: `parErr` is high in cycle n+2 exactly when cycle n held a valid word owned by the other agent and the ones across that word and the `parIn` sampled in cycle n+1 are odd in count.
- R8: Corrupted data, byte enables or parity on wait states, idle cycles, or words this agent owns never raise `parErr`.
- R9: A single flipped bit in any position of `adIn`, in `cbeIn`, or on `parIn` for a word owned by the other agent raises exactly one `parErr` pulse for that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| adIn | input | AD_W | Address/data pins as sampled |
| cbeIn | input | BE_W | Command/byte-enable pins as sampled |
| frameN | input | 1 | Transaction frame strobe, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| isMaster | input | 1 | 1 when this agent is the initiator |
| isWrite | input | 1 | 1 for a write transfer, 0 for a read |
| parIn | input | 1 | Parity pin as sampled |
| parOut | output | 1 | Parity value for the previous cycle's word |
| parOe | output | 1 | Enable for the parity pin driver |
| parErr | output | 1 | One-cycle parity mismatch flag |

## Verification
The bench builds the block with its default widths, 32 data bits and 4 byte-enable bits. At these widths, single-bit flips can reach the lowest and highest data bits, a middle data bit, and every byte-enable lane. The flips are applied in the address cycle and in later data words, for both roles and both directions. With the full width in place, the bench can also show that a flip in a word this agent owns, in a wait state, or on an idle bus leaves the error flag low.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;

  // Per-cycle classification handed from control to datapath.
  typedef struct packed {
    logic wordValid;  // this cycle carries a valid bus word
    logic wordOurs;   // this agent owns that word
  } phaseStrobe_t;

endpackage

// File: rtl/bus_parity_ctl.sv
module bus_parity_ctl
  import bus_parity_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameN,
  input  logic         irdyN,
  input  logic         trdyN,
  input  logic         isMaster,
  input  logic         isWrite,
  output phaseStrobe_t strobe
);

  logic busBusyQ;
  logic busIdle;
  logic addrCycle;
  logic dataValid;
  logic dataOwnerIsMaster;

  assign busIdle   = frameN & irdyN;
  assign addrCycle = ~frameN & ~busBusyQ;

  // Writes qualify on the initiator strobe, reads on the target strobe.
  assign dataValid = busBusyQ & ~busIdle & (isWrite ? ~irdyN : ~trdyN);

  // Writes: initiator owns the data word; reads: target owns it.
  assign dataOwnerIsMaster = isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busBusyQ <= 1'b0;
    else       busBusyQ <= ~busIdle;
  end

  always_comb begin
    strobe.wordValid = addrCycle | dataValid;
    if (addrCycle) strobe.wordOurs = isMaster;
    else           strobe.wordOurs = dataOwnerIsMaster ? isMaster : ~isMaster;
  end

endmodule

// File: rtl/bus_parity_dp.sv
module bus_parity_dp
  import bus_parity_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AD_W-1:0] adIn,
  input  logic [BE_W-1:0] cbeIn,
  input  logic            parIn,
  input  phaseStrobe_t    strobe,
  output logic            parOut,
  output logic            parOe,
  output logic            parErr
);

  localparam int WORD_W = AD_W + BE_W;

  logic [WORD_W-1:0] busWord;
  logic              wordParity;
  logic              parQ;
  logic              driveQ;
  logic              checkQ;
  logic              errQ;

  assign busWord    = {cbeIn, adIn};
  assign wordParity = ^busWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parQ   <= 1'b0;
      driveQ <= 1'b0;
      checkQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      parQ   <= wordParity;
      driveQ <= strobe.wordValid & strobe.wordOurs;
      checkQ <= strobe.wordValid & ~strobe.wordOurs;
      errQ   <= checkQ & (parIn ^ parQ);
    end
  end

  assign parOut = parQ;
  assign parOe  = driveQ;
  assign parErr = errQ;

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bus_parity_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AD_W-1:0] adIn,
  input  logic [BE_W-1:0] cbeIn,
  input  logic            frameN,
  input  logic            irdyN,
  input  logic            trdyN,
  input  logic            isMaster,
  input  logic            isWrite,
  input  logic            parIn,
  output logic            parOut,
  output logic            parOe,
  output logic            parErr
);

  phaseStrobe_t strobe;

  bus_parity_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .trdyN    (trdyN),
    .isMaster (isMaster),
    .isWrite  (isWrite),
    .strobe   (strobe)
  );

  bus_parity_dp #(.AD_W(AD_W), .BE_W(BE_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .adIn   (adIn),
    .cbeIn  (cbeIn),
    .parIn  (parIn),
    .strobe (strobe),
    .parOut (parOut),
    .parOe  (parOe),
    .parErr (parErr)
  );

endmodule

// File: rtl/bus_parity_chk.sv
module bus_parity_chk #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [AD_W-1:0] adIn,
  input logic [BE_W-1:0] cbeIn,
  input logic            frameN,
  input logic            irdyN,
  input logic            parIn,
  input logic            parOut,
  input logic            parOe,
  input logic            parErr
);

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!parOe && !parErr);
    end
  end

  // R2: parity pin value tracks the previous cycle's word
  assert_par_lag_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (parOut == ^{$past(cbeIn), $past(adIn)}));

  // R6: no drive after an idle bus cycle
  assert_oe_after_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> $past(!frameN || !irdyN));

  // R7: an error flag follows a real mismatch on the pin
  assert_err_mismatch_R7: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> $past(parIn != parOut));

  // R8: never flag a word this agent drove itself
  assert_err_not_own_R8: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> !$past(parOe));

endmodule

bind bus_parity_unit bus_parity_chk #(.AD_W(AD_W), .BE_W(BE_W)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .adIn   (adIn),
  .cbeIn  (cbeIn),
  .frameN (frameN),
  .irdyN  (irdyN),
  .parIn  (parIn),
  .parOut (parOut),
  .parOe  (parOe),
  .parErr (parErr)
);

// File: tb/sim_bus_parity_unit.sv
module sim_bus_parity_unit;
  localparam int AW = 32;
  localparam int BW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic [AW-1:0] adIn;
  logic [BW-1:0] cbeIn;
  logic          frameN, irdyN, trdyN, isMaster, isWrite, parIn;
  logic          parOut, parOe, parErr;

  int checks = 0;
  int fails  = 0;

  bus_parity_unit #(.AD_W(AW), .BE_W(BW)) u0 (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeIn(cbeIn),
    .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .isMaster(isMaster), .isWrite(isWrite), .parIn(parIn),
    .parOut(parOut), .parOe(parOe), .parErr(parErr)
  );

  // Bit that brings the total count of ones to an even number.
  function automatic logic evenFill(input logic [AW-1:0] a, input logic [BW-1:0] c);
    int n = 0;
    for (int i = 0; i < AW; i++) n += int'(a[i]);
    for (int i = 0; i < BW; i++) n += int'(c[i]);
    return (n % 2 == 1) ? 1'b1 : 1'b0;
  endfunction

  // Behavioural reference, advanced on each rising edge.
  logic          mBusy, mChk, mExpPar, mExpOe, mExpErr;
  logic [AW-1:0] mAd;
  logic [BW-1:0] mCbe;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mChk = 0; mExpPar = 0; mExpOe = 0; mExpErr = 0;
      mAd = '0; mCbe = '0;
    end else begin
      logic idle, addr, valid, ours;
      mExpErr = mChk && (evenFill(mAd, mCbe) != parIn);
      idle  = frameN && irdyN;
      addr  = !frameN && !mBusy;
      valid = addr || (mBusy && !idle && ((isWrite && !irdyN) || (!isWrite && !trdyN)));
      if (addr)         ours = isMaster;
      else if (isWrite) ours = isMaster;
      else              ours = !isMaster;
      mExpOe  = valid && ours;
      mChk    = valid && !ours;
      mExpPar = evenFill(adIn, cbeIn);
      mAd = adIn; mCbe = cbeIn;
      mBusy = !idle;
    end
  end

  task automatic check1(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  logic [AW-1:0] prevAd  = '0;
  logic [BW-1:0] prevCbe = '0;
  logic          pendFlip = 1'b0;
  int            seenErr  = 0;

  task automatic drive(input logic [AW-1:0] ad, input logic [BW-1:0] cbe,
                       input logic f, input logic i, input logic t,
                       input logic [AW-1:0] adF, input logic [BW-1:0] cbeF,
                       input logic parFlipNext);
    @(negedge clk);
    check1("R2", "parOut", int'(parOut), int'(mExpPar));
    check1("R6", "parOe",  int'(parOe),  int'(mExpOe));
    check1("R7", "parErr", int'(parErr), int'(mExpErr));
    if (parErr) seenErr++;
    parIn  = evenFill(prevAd, prevCbe) ^ pendFlip;
    adIn   = ad ^ adF;
    cbeIn  = cbe ^ cbeF;
    frameN = f; irdyN = i; trdyN = t;
    prevAd = ad; prevCbe = cbe; pendFlip = parFlipNext;
  endtask

  task automatic idleCycle(input logic [AW-1:0] junk, input logic parJunk);
    drive('0, '0, 1'b1, 1'b1, 1'b1, junk, '0, parJunk);
  endtask

  // kind: 0 none, 1 data bit, 2 byte-enable bit, 3 parity pin
  task automatic runTxn(input logic master, input logic write, input int nData,
                        input int kind, input int injAt, input int injBit,
                        input logic onWaits);
    int    hit = 0;
    string req;
    seenErr  = 0;
    isMaster = master;
    isWrite  = write;
    for (int k = 0; k <= nData; k++) begin
      logic [AW-1:0] ad, adF;
      logic [BW-1:0] cbe, cbeF;
      logic          pF, own, f, i, t;
      ad  = (32'hA5C3_0F1E << k) ^ (32'h0101_0101 * (k + 1));
      cbe = BW'(k * 3 + 1);
      adF = '0; cbeF = '0; pF = 1'b0;
      if (k >= 2 && (k % 2 == 0)) begin
        if (onWaits) begin
          adF = AW'(1) << injBit; cbeF = BW'(1) << (injBit % BW); pF = 1'b1;
        end
        drive(ad ^ 32'h00FF_0000, cbe, 1'b0, write ? 1'b1 : 1'b0, write ? 1'b0 : 1'b1,
              adF, cbeF, pF);
        adF = '0; cbeF = '0; pF = 1'b0;
      end
      if (k == 0) begin f = 1'b0; i = 1'b1; t = 1'b1; end
      else begin f = (k == nData); i = 1'b0; t = 1'b0; end
      own = (k == 0) ? master : (write ? master : !master);
      if (kind != 0 && k == injAt) begin
        if (kind == 1) adF  = AW'(1) << injBit;
        if (kind == 2) cbeF = BW'(1) << (injBit % BW);
        if (kind == 3) pF   = 1'b1;
        if (!own) hit = 1;
      end
      drive(ad, cbe, f, i, t, adF, cbeF, pF);
    end
    idleCycle('0, 1'b0);
    idleCycle('0, 1'b0);
    idleCycle('0, 1'b0);
    if (onWaits)          req = "R8";
    else if (kind == 0)   req = write ? "R4" : "R5";
    else if (injAt == 0)  req = hit ? "R3" : "R8";
    else if (hit == 0)    req = "R8";
    else                  req = "R9";
    check1(req, "errorPulses", seenErr, hit);
  endtask

  initial begin
    rstN = 1'b0; adIn = '0; cbeIn = '0; frameN = 1'b1; irdyN = 1'b1; trdyN = 1'b1;
    isMaster = 1'b1; isWrite = 1'b1; parIn = 1'b0;
    repeat (3) @(negedge clk);
    check1("R1", "parOe",  int'(parOe),  0);
    check1("R1", "parErr", int'(parErr), 0);
    check1("R1", "parOut", int'(parOut), 0);
    rstN = 1'b1;
    idleCycle('0, 1'b0);
    idleCycle(32'hDEAD_BEEF, 1'b1);  // junk on an idle bus: R8
    idleCycle(32'h1234_5678, 1'b1);
    idleCycle('0, 1'b0);

    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++) begin
        runTxn(m[0], w[0], 4, 0, 0, 0, 1'b0);
        runTxn(m[0], w[0], 4, 0, 0, 5, 1'b1);
        for (int kind = 1; kind <= 3; kind++)
          for (int at = 0; at <= 3; at++) begin
            int bitSel;
            case (at)
              0: bitSel = 0;
              1: bitSel = 31;
              2: bitSel = 17;
              default: bitSel = 8 + kind;
            endcase
            runTxn(m[0], w[0], 4, kind, at, bitSel, 1'b0);
          end
        for (int b = 0; b < BW; b++)
          runTxn(m[0], w[0], 3, 2, 3, b, 1'b0);
      end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule